// File: doc/BRIEF.md
# Block Register Save and Restore Sequencer

This controller carries out a single stack instruction that moves a run of adjacent registers to or from memory. The run goes through a stack pointer, and any general register can serve as that pointer. A decoder hands it a start pulse together with the direction, a base register field, a word count and the number of the register that holds the pointer. The sequencer first reads the pointer from the register file. It then moves one word per clock between the register file and memory. Finally it writes the updated pointer back and raises `done` for one cycle.

The register file has eight entries. The registers moved are the ones above the base field, so index 0 can never be part of a run. Index 8 refers to the flags register, which holds the interrupt enables and sits outside the register file. Because of this, a restore of three words based at register 5 brings back R6, R7 and the flags, which is the return-from-interrupt form. A restore of two words from the same base brings back R6 and R7 only, which is the return-from-function form. A save walks the run from the top index down and a restore walks it from the bottom index up, so a save followed by a matching restore puts every value back where it came from. Memory is assumed to return read data in the same cycle as its address. Opcode decode happens outside this block.

Top module: `stk_block_mover`

## Requirements
- R1: After reset, `busy`, `done`, `rf_we`, `mem_we`, `mem_re` and `flg_we` are all 0.
- R2: Call the clock cycle that samples `start` in idle cycle 0. With effective count n > 0, `done` is high in cycle n+2 and the n transfers happen in cycles 2 to n+1. With n = 0, `done` is high in cycle 1. `done` is never high for two cycles in a row.
- R3: Save (`push`=1) goes through registers base+n down to base+1. The k-th transfer (k from 0) writes that register's value to memory address SP-k.
- R4: Restore (`push`=0) goes through registers base+1 up to base+n. The k-th transfer reads memory address SP+1+k and writes the word to that register.
- R5: When `done` is high and n > 0, the register named by `sp_reg` is written with SP-n for a save or SP+n for a restore, modulo 2^16. This write comes after every transfer.
- R6: The effective count is n = min(count, 8-base). Index 8 is the flags register: a save reads it from `flg_rdata`, and a restore writes it through `flg_we`/`flg_wdata` with no register-file write in that cycle.
- R7: A restore with base 5, count 2 and `sp_reg` 0 loads R6 and R7 from SP+1 and SP+2, leaves the flags unchanged and sets R0 to SP+2.
- R8: A restore with base 5, count 3 and `sp_reg` 0 loads R6, R7 and the flags from SP+1, SP+2 and SP+3, and sets R0 to SP+3.
- R9: With n = 0 there is no memory access, no register write and no pointer change.
- R10: A `start` that arrives while `busy` is 1 is ignored. It does not change the running operation and does not start a second one.
- R11: `mem_we` and `mem_re` are never high together. Register 0 is never written as transfer data, only as the pointer in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, sampled only while idle |
| push | input | 1 | 1 = save registers to memory, 0 = restore them |
| base_reg | input | 3 | The run begins just above this index |
| count | input | 3 | Number of words requested |
| sp_reg | input | 3 | Register that holds the stack pointer |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at completion |
| rf_raddr | output | 3 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| flg_rdata | input | 16 | Current value of the flags register |
| flg_we | output | 1 | Flags register write enable |
| flg_wdata | output | 16 | New flags value |

## Verification
A fault in the index counter puts the wrong registers or the flags into the run. The bench sees this in the register and memory images right after the pulse on `done`. A fault in the pointer shows up as transfers at shifted addresses or as a wrong write-back value, also visible after a single operation. A fault in the remaining-count logic moves the `done` pulse off cycle n+2, and the bench catches that within that operation's own cycle window. Pairs of saves and restores, runs clipped at the flags index, pointer wrap-around and starts issued mid-operation are each exercised, so every one of these faults shows up at the ports.

// File: rtl/stk_pkg.sv
// Shared types for the block register save/restore sequencer.
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_XFER = 2'd2,
        ST_FIN  = 2'd3
    } stk_state_e;
endpackage

// File: rtl/stk_seq.sv
// Sequencer: takes in an instruction, clips its count, steps the register
// index and counts down the remaining transfers.
// Assumes: REG_N == 2**IDX_W, and index REG_N stands for the flags register.
module stk_seq
    import stk_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int REG_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             push,
    input  logic [IDX_W-1:0] base_reg,
    input  logic [IDX_W-1:0] count,
    input  logic [IDX_W-1:0] sp_reg,
    output stk_state_e       state,
    output logic [IDX_W:0]   cur_idx,
    output logic             push_q,
    output logic [IDX_W-1:0] sp_sel_q,
    output logic             zero_q
);
    localparam int CW = IDX_W + 1;

    logic [CW-1:0] room;
    logic [CW-1:0] n_eff;
    logic [CW-1:0] left_q;

    // Clip the requested count so that the run stops at the flags index.
    always_comb begin
        room  = CW'(REG_N) - {1'b0, base_reg};
        n_eff = ({1'b0, count} < room) ? {1'b0, count} : room;
    end

    // State, index and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_idx  <= '0;
            left_q   <= '0;
            push_q   <= 1'b0;
            sp_sel_q <= '0;
            zero_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    push_q   <= push;
                    sp_sel_q <= sp_reg;
                    left_q   <= n_eff;
                    zero_q   <= (n_eff == '0);
                    cur_idx  <= push ? ({1'b0, base_reg} + n_eff)
                                     : ({1'b0, base_reg} + CW'(1));
                    state    <= (n_eff == '0) ? ST_FIN : ST_LOAD;
                end
                ST_LOAD: state <= ST_XFER;
                ST_XFER: begin
                    cur_idx <= push_q ? cur_idx - CW'(1) : cur_idx + CW'(1);
                    left_q  <= left_q - CW'(1);
                    if (left_q == CW'(1)) state <= ST_FIN;
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: every transfer targets an index in 1..REG_N, so R0 never takes part.
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> (cur_idx >= CW'(1) && cur_idx <= CW'(REG_N)));

    // R9: an empty run goes straight to completion.
    p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && n_eff == '0) |=> (state == ST_FIN));

    // R10: once an operation has started, it does not fall back to idle before finishing.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD || state == ST_XFER) |=> (state != ST_IDLE));
endmodule

// File: rtl/stk_ptr.sv
// Pointer unit: holds the address of the current transfer. A save starts at
// SP and counts down. A restore starts at SP+1 and counts up. It also gives
// the value of SP to write back at the end.
// Assumes: load and step are never high in the same cycle.
module stk_ptr #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          push,
    input  logic [DW-1:0] sp_in,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] sp_final
);
    // Address register: loaded from the pointer register, then stepped once per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= push ? sp_in : sp_in + DW'(1);
        else if (step) addr <= push ? addr - DW'(1) : addr + DW'(1);
    end

    // After the last step, a restore's address sits one past the final word.
    always_comb sp_final = push ? addr : addr - DW'(1);

    // R3/R4: each transfer moves the address by exactly one word.
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + DW'(1)
                          || addr == $past(addr) - DW'(1)));
endmodule

// File: rtl/stk_block_mover.sv
// Top level of the block register save/restore sequencer. Connects the
// sequencer and the pointer unit to a register-file port, a memory port and
// the flags register.
// Assumes: register-file and memory reads are combinational, and the decoder
// only raises start for legal save/restore forms.
module stk_block_mover
    import stk_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IDX_W = 3,
    parameter int REG_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             push,
    input  logic [IDX_W-1:0] base_reg,
    input  logic [IDX_W-1:0] count,
    input  logic [IDX_W-1:0] sp_reg,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] rf_raddr,
    input  logic [DW-1:0]    rf_rdata,
    output logic             rf_we,
    output logic [IDX_W-1:0] rf_waddr,
    output logic [DW-1:0]    rf_wdata,
    output logic [DW-1:0]    mem_addr,
    output logic             mem_we,
    output logic             mem_re,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    flg_rdata,
    output logic             flg_we,
    output logic [DW-1:0]    flg_wdata
);
    stk_state_e       state;
    logic [IDX_W:0]   cur_idx;
    logic             push_q;
    logic [IDX_W-1:0] sp_sel_q;
    logic             zero_q;
    logic [DW-1:0]    sp_final;
    logic             xfer;
    logic             is_flag;

    stk_seq #(.IDX_W(IDX_W), .REG_N(REG_N)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .push(push),
        .base_reg(base_reg), .count(count), .sp_reg(sp_reg),
        .state(state), .cur_idx(cur_idx), .push_q(push_q),
        .sp_sel_q(sp_sel_q), .zero_q(zero_q)
    );

    stk_ptr #(.DW(DW)) i_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_LOAD), .step(state == ST_XFER),
        .push(push_q), .sp_in(rf_rdata),
        .addr(mem_addr), .sp_final(sp_final)
    );

    // Port steering: pointer read, then transfers, then pointer write-back.
    always_comb begin
        xfer      = (state == ST_XFER);
        is_flag   = cur_idx[IDX_W];
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        rf_raddr  = (state == ST_LOAD) ? sp_sel_q : cur_idx[IDX_W-1:0];
        mem_we    = xfer && push_q;
        mem_re    = xfer && !push_q;
        mem_wdata = is_flag ? flg_rdata : rf_rdata;
        flg_we    = xfer && !push_q && is_flag;
        flg_wdata = mem_rdata;
        rf_we     = (xfer && !push_q && !is_flag) || (done && !zero_q);
        rf_waddr  = done ? sp_sel_q : cur_idx[IDX_W-1:0];
        rf_wdata  = done ? sp_final : mem_rdata;
    end

    // R11: a transfer cycle either reads memory or writes it, never both.
    p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11: register 0 is written only as the pointer at completion.
    p_no_r0_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |-> (rf_waddr != '0));

    // R2: done lasts a single cycle.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an empty run writes nothing at completion.
    p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> !rf_we);
endmodule

// File: tb/test_stk_block_mover.sv
module test_stk_block_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        push = 1'b0;
    logic [2:0]  base_reg = '0, count = '0, sp_reg = '0;
    logic        busy, done, rf_we, mem_we, mem_re, flg_we;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
    logic [15:0] flg_wdata;

    logic [15:0] regs [8];
    logic [15:0] mem  [256];
    logic [15:0] flags;

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;

    always #2 clk = ~clk;

    stk_block_mover i_stk_block_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .push(push),
        .base_reg(base_reg), .count(count), .sp_reg(sp_reg),
        .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .flg_rdata(flags), .flg_we(flg_we), .flg_wdata(flg_wdata)
    );

    // Environment: register file, memory (low 8 address bits) and flags.
    assign rf_rdata  = regs[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (rf_we)  regs[rf_waddr] <= rf_wdata;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (flg_we) flags <= flg_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port-level monitor for R11.
    always @(negedge clk) begin
        if (rst_n && mem_we && mem_re) begin
            checks++; fails++;
            $display("FAIL R11 actual=%0h expected=%0h", 1, 0);
        end
        if (rst_n && rf_we && !done && rf_waddr == 3'd0) begin
            checks++; fails++;
            $display("FAIL R11 actual=%0h expected=%0h", rf_waddr, 1);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total == 150000) begin
            fails++;
            $display("FAIL R2 watchdog actual=%0h expected=%0h", cyc_total, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int eff_n(input int a, input int c);
        return (c < 8 - a) ? c : 8 - a;
    endfunction

    // Run one operation and compare the resulting state with the expected model.
    task automatic do_op(input bit p, input int a, input int c, input int s,
                         input logic [15:0] spv, input string tg, input bit poke);
        logic [15:0] er [8];
        logic [15:0] em [256];
        logic [15:0] ef;
        logic [15:0] newsp;
        int n, cyc, expc;
        regs[s] = spv;
        for (int i = 0; i < 8; i++) er[i] = regs[i];
        for (int i = 0; i < 256; i++) em[i] = mem[i];
        ef = flags;
        n = eff_n(a, c);
        if (p) begin
            for (int k = 0; k < n; k++) begin
                int i = a + n - k;
                logic [15:0] ad = spv - 16'(k);
                em[ad[7:0]] = (i == 8) ? flags : regs[i];
            end
            newsp = spv - 16'(n);
        end else begin
            for (int k = 0; k < n; k++) begin
                int i = a + 1 + k;
                logic [15:0] ad = spv + 16'(1 + k);
                if (i == 8) ef = mem[ad[7:0]];
                else er[i] = mem[ad[7:0]];
            end
            newsp = spv + 16'(n);
        end
        if (n != 0) er[s] = newsp;

        @(negedge clk);
        push = p; base_reg = 3'(a); count = 3'(c); sp_reg = 3'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (n == 0 && (rf_we || mem_we || mem_re))
                chk(0, {tg, " R9 access"}, 1, 0);
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1; push = ~p; count = 3'd7; base_reg = 3'd0;
            end
            if (poke && cyc == 3) start = 1'b0;
        end
        expc = (n == 0) ? 1 : n + 2;
        chk(cyc == expc, {tg, " R2 done cycle"}, cyc, expc);
        if (n == 0)
            chk(!rf_we && !mem_we && !mem_re, {tg, " R9 quiet"},
                {rf_we, mem_we, mem_re}, 0);
        @(negedge clk);
        chk(!done, {tg, " R2 pulse"}, done, 0);
        for (int i = 0; i < 8; i++)
            if (regs[i] !== er[i])
                chk(0, (i == s) ? {tg, " R5 sp"} : {tg, p ? " R3 reg" : " R4 reg"},
                    regs[i], er[i]);
        checks++;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== em[i]) chk(0, {tg, " R3 mem"}, mem[i], em[i]);
        checks++;
        chk(flags === ef, {tg, " R6 flags"}, flags, ef);
        if (poke) begin
            int extra = 0;
            for (int j = 0; j < 10; j++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk(extra == 0, {tg, " R10 no restart"}, extra, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        flags = 16'h00A5;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!rf_we && !mem_we && !mem_re && !flg_we, "R1 strobes",
            {rf_we, mem_we, mem_re, flg_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(1, 1, 3, 0, 16'd100, "save",     0);
        do_op(0, 1, 3, 0, 16'd97,  "restore",  0);
        chk(regs[0] == 16'd100, "R4 pair sp", regs[0], 100);
        do_op(0, 5, 2, 0, 16'd60,  "R7 fret",  0);
        do_op(0, 5, 3, 0, 16'd70,  "R8 iret",  0);
        do_op(1, 6, 5, 2, 16'd150, "R6 clip",  0);
        do_op(0, 7, 4, 1, 16'd40,  "R6 flag",  0);
        do_op(1, 3, 0, 0, 16'd80,  "R9 zero",  0);
        do_op(0, 2, 0, 4, 16'd80,  "R9 zero",  0);
        do_op(1, 0, 3, 5, 16'd1,   "R5 wrap",  0);
        do_op(0, 0, 4, 6, 16'hFFFE,"R5 wrap",  0);
        do_op(0, 2, 4, 3, 16'd120, "R5 inrun", 0);
        do_op(1, 1, 5, 0, 16'd200, "R10 busy", 1);
        do_op(0, 4, 3, 7, 16'd30,  "R10 busy", 1);

        for (int t = 0; t < 40; t++) begin
            int a = int'($urandom_range(0, 7));
            int c = int'($urandom_range(0, 7));
            int s = int'($urandom_range(0, 7));
            bit p = 1'($urandom);
            do_op(p, a, c, s, 16'($urandom_range(32, 223)), "rand", 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule